// File: doc/BRIEF.md
# Tick-Scaled Watchdog Timer

This block is a watchdog timer with two 32-bit registers on a simple register bus. The bus has an address, a write enable, write data and combinational read data. Software programs a 20-bit reload count, a 4-bit tick resolution and two enable bits through the control word. The live remaining count can be read back through a second word, which is read-only.

The counter steps down once per tick. A tick lasts 1/2^resolution of a second, derived from a reference clock whose rate in cycles per second is the parameter `REF_HZ`.

An accepted control write does not take effect at once. It opens a load window of `LOAD_CYCLES` clock cycles. During that window the counter is frozen and a busy flag reads back as 1. When the window closes, the counter takes the new reload value and the tick prescaler restarts. Firmware keeps the watchdog alive by rewriting the count before it runs out. If the count reaches zero while both enables are set, a sticky reset request is raised.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the control word reads 0x00000000, the count word reads 0x00000000 and `resetReq` is low.
- R2: The control word at byte offset 0x0 holds the reload count in bits 19:0, the resolution in bits 23:20, the reset enable in bit 26 and the count enable in bit 27. Bits 24, 25 and 29 to 31 ignore writes and read as 0.
- R3: An accepted control write makes bit 28 of the control word read 1 for exactly `LOAD_CYCLES` cycles, after which it clears by itself.
- R4: A control write that arrives while bit 28 is 1 is ignored entirely.
- R5: The count word at byte offset 0x4 returns the live count in bits 19:0, with bits 31:20 reading 0. Writes to it have no effect.
- R6: While the load window is open the counter holds its value. At the end of the window the counter holds the reload value.
- R7: While counting is enabled and the load window is closed, the counter decrements by one every P cycles, where P = max(1, REF_HZ >> resolution).
- R8: With both enables set, `resetReq` rises in the cycle after the counter is zero. For reload N this is LOAD_CYCLES + N*P + 1 cycles after the write edge. The request then stays high until reset, even if the watchdog is later disabled.
- R9: With the reset enable clear, the counter stops at zero and `resetReq` stays low.
- R10: With the count enable clear, the counter holds and no request is raised, even at zero.
- R11: Rewriting the control word before expiry restarts the count from the new reload value, so periodic rewrites prevent `resetReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register |
| busWe | input | 1 | Write strobe for one cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr` (combinational) |
| resetReq | output | 1 | Sticky system reset request |

## Verification
The bench builds the block with `REF_HZ` = 8 and `LOAD_CYCLES` = 3. With these values the tick period is 8, 4, 2 or 1 cycles for resolutions 0 to 3, and it saturates at 1 cycle from resolution 4 upward. A small value of 8 makes every resolution class, including the saturated one, reachable within a few dozen cycles. The bench therefore sweeps each resolution from 0 to 4 against reloads 0 to 3. For each pair it predicts the exact expiry cycle as 3 + N*P + 1, and it tracks a slower countdown step by step.

// File: rtl/tick_wdog_pkg.sv
`timescale 1ns/1ps
package tick_wdog_pkg;
  localparam int CNT_W   = 20;
  localparam int RES_W   = 4;
  localparam int RES_LSB = 20;
  localparam int RST_BIT = 26;
  localparam int RUN_BIT = 27;
  localparam int BSY_BIT = 28;
  localparam logic [31:0] WR_MASK = 32'h0CFF_FFFF;

  typedef struct packed {
    logic             loadDone;
    logic             busy;
    logic             runEn;
    logic             rstEn;
    logic [RES_W-1:0] res;
    logic [CNT_W-1:0] reload;
  } ctrlStrobes_t;
endpackage

// File: rtl/tick_wdog_ctrl.sv
`timescale 1ns/1ps
module tick_wdog_ctrl
  import tick_wdog_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int LOAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  input  logic [CNT_W-1:0]  liveCount,
  output ctrlStrobes_t      strobes,
  output logic [31:0]       busRdata
);
  localparam int LW = $clog2(LOAD_CYCLES + 1);
  localparam logic [ADDR_W-1:0] CTRL_OFS  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] COUNT_OFS = ADDR_W'(4);
  localparam logic [LW-1:0] LOAD_INIT = LW'(LOAD_CYCLES);

  logic [31:0]   ctrlQ;
  logic [LW-1:0] loadLeft;
  logic          busy;
  logic          wrAccept;

  assign busy     = (loadLeft != '0);
  assign wrAccept = busWe && (busAddr == CTRL_OFS) && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      loadLeft <= '0;
    end else if (wrAccept) begin
      ctrlQ    <= busWdata & WR_MASK;
      loadLeft <= LOAD_INIT;
    end else if (busy) begin
      loadLeft <= loadLeft - LW'(1);
    end
  end

  always_comb begin
    strobes.loadDone = (loadLeft == LW'(1));
    strobes.busy     = busy;
    strobes.runEn    = ctrlQ[RUN_BIT];
    strobes.rstEn    = ctrlQ[RST_BIT];
    strobes.res      = ctrlQ[RES_LSB +: RES_W];
    strobes.reload   = ctrlQ[CNT_W-1:0];
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == CTRL_OFS) begin
      busRdata          = ctrlQ;
      busRdata[BSY_BIT] = busy;
    end else if (busAddr == COUNT_OFS) begin
      busRdata[CNT_W-1:0] = liveCount;
    end
  end
endmodule

// File: rtl/tick_wdog_prescaler.sv
`timescale 1ns/1ps
module tick_wdog_prescaler
  import tick_wdog_pkg::*;
#(
  parameter int REF_HZ = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             run,
  input  logic [RES_W-1:0] res,
  output logic             tick
);
  localparam int PRE_W = (REF_HZ > 1) ? $clog2(REF_HZ + 1) : 1;
  localparam logic [PRE_W-1:0] REF_V = PRE_W'(REF_HZ);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] shifted;
  logic [PRE_W-1:0] lastStep;

  assign shifted  = REF_V >> res;
  assign lastStep = (shifted == '0) ? '0 : shifted - PRE_W'(1);
  assign tick     = run && (preCnt >= lastStep);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      preCnt <= '0;
    end else if (run) begin
      preCnt <= tick ? '0 : preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tick_wdog_datapath.sv
`timescale 1ns/1ps
module tick_wdog_datapath
  import tick_wdog_pkg::*;
#(
  parameter int REF_HZ = 32768
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] liveCount,
  output logic             resetReq
);
  logic running;
  logic tick;

  assign running = strobes.runEn && !strobes.busy;

  tick_wdog_prescaler #(.REF_HZ(REF_HZ)) u_pre (
    .clk     (clk),
    .rstN    (rstN),
    .restart (strobes.loadDone),
    .run     (running),
    .res     (strobes.res),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      liveCount <= '0;
    end else if (strobes.loadDone) begin
      liveCount <= strobes.reload;
    end else if (tick && (liveCount != '0)) begin
      liveCount <= liveCount - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resetReq <= 1'b0;
    end else if (running && strobes.rstEn && (liveCount == '0)) begin
      resetReq <= 1'b1;
    end
  end
endmodule

// File: rtl/tick_watchdog.sv
`timescale 1ns/1ps
module tick_watchdog
  import tick_wdog_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int REF_HZ      = 32768,
  parameter int LOAD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              resetReq
);
  ctrlStrobes_t     strobes;
  logic [CNT_W-1:0] liveCount;

  tick_wdog_ctrl #(.ADDR_W(ADDR_W), .LOAD_CYCLES(LOAD_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWdata  (busWdata),
    .liveCount (liveCount),
    .strobes   (strobes),
    .busRdata  (busRdata)
  );

  tick_wdog_datapath #(.REF_HZ(REF_HZ)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .liveCount (liveCount),
    .resetReq  (resetReq)
  );
endmodule

// File: rtl/tick_wdog_checker.sv
`timescale 1ns/1ps
module tick_wdog_checker
  import tick_wdog_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busy,
  input logic              runEn,
  input logic              rstEn,
  input logic [CNT_W-1:0]  liveCount,
  input logic              resetReq
);
  AST_LOAD_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(busWe && (busAddr == '0))); // R3

  AST_FROZEN_IN_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    busy ##1 busy |-> $stable(liveCount)); // R6

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && liveCount != '0) |=>
      (liveCount == $past(liveCount) || liveCount == $past(liveCount) - CNT_W'(1))); // R7

  AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> $past(runEn && rstEn && !busy && liveCount == '0)); // R8

  AST_REQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> resetReq); // R8

  AST_HOLD_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (liveCount == '0 && !busy) |=> (liveCount == '0)); // R9

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !busy) |=> $stable(liveCount)); // R10
endmodule

bind tick_watchdog tick_wdog_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busy      (strobes.busy),
  .runEn     (strobes.runEn),
  .rstEn     (strobes.rstEn),
  .liveCount (liveCount),
  .resetReq  (resetReq)
);

// File: tb/tick_watchdog_bench.sv
`timescale 1ns/1ps
module tick_watchdog_bench;
  localparam int REF = 8;
  localparam int LDC = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        resetReq;
  int          tests = 0;
  int          fails = 0;
  logic [31:0] rd;

  always #10 clk = ~clk;

  tick_watchdog #(.ADDR_W(3), .REF_HZ(REF), .LOAD_CYCLES(LDC)) u_tick_watchdog (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .resetReq(resetReq)
  );

  function automatic logic [31:0] mkCtrl(input logic run, input logic rst,
                                         input logic [3:0] res, input logic [19:0] cnt);
    return {4'b0, run, rst, 2'b0, res, cnt};
  endfunction

  function automatic int period(input int res);
    int p;
    p = REF >> res;
    return (p == 0) ? 1 : p;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    busWe = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic measure(output int k);
    k = 0;
    while (!resetReq && k < 500) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog R1..all actual=hung expected=done");
    finishRun();
  end

  initial begin
    int k;
    doReset();
    // R1 reset state
    rdReg(3'd0, rd); check("R1 ctrl after reset", rd, 32'h0);
    rdReg(3'd4, rd); check("R1 count after reset", rd, 32'h0);
    check("R1 resetReq after reset", {31'b0, resetReq}, 32'h0);

    // R2 layout and reserved bits, R3 busy window, R6 load value
    wr(3'd0, 32'hFFFF_FFFF);
    rdReg(3'd0, rd); check("R2 R3 ctrl readback while loading", rd, 32'h1CFF_FFFF);
    repeat (LDC - 1) @(negedge clk);
    rdReg(3'd0, rd); check("R3 busy still set at last load cycle", {31'b0, rd[28]}, 32'h1);
    @(negedge clk);
    rdReg(3'd0, rd); check("R2 R3 ctrl after load", rd, 32'h0CFF_FFFF);
    rdReg(3'd4, rd); check("R6 count loaded at end of window", rd, 32'h000F_FFFF);

    // R4 write during load ignored
    doReset();
    wr(3'd0, mkCtrl(1, 0, 4'd2, 20'd5));
    wr(3'd0, mkCtrl(0, 1, 4'd1, 20'd9));
    repeat (3) @(negedge clk);
    rdReg(3'd0, rd); check("R4 second write dropped", rd, mkCtrl(1, 0, 4'd2, 20'd5));

    // R5 count word read-only
    doReset();
    wr(3'd0, mkCtrl(0, 0, 4'd0, 20'h123));
    repeat (3) @(negedge clk);
    wr(3'd4, 32'hFFFA_BCDE);
    rdReg(3'd4, rd); check("R5 count write ignored", rd, 32'h0000_0123);
    rdReg(3'd0, rd); check("R5 ctrl untouched by count write", rd, mkCtrl(0, 0, 4'd0, 20'h123));

    // R8 expiry timing sweep, R7 period per resolution
    for (int r = 0; r <= 4; r++) begin
      for (int n = 0; n <= 3; n++) begin
        doReset();
        wr(3'd0, mkCtrl(1, 1, 4'(r), 20'(n)));
        measure(k);
        check($sformatf("R8 R7 expiry res=%0d n=%0d", r, n), 32'(k),
              32'(LDC + n * period(r) + 1));
      end
    end
    // R8 sticky after disabling
    wr(3'd0, mkCtrl(0, 0, 4'd0, 20'd7));
    repeat (10) @(negedge clk);
    check("R8 request stays high", {31'b0, resetReq}, 32'h1);

    // R7 stepwise countdown, R9 stop at zero without reset enable
    doReset();
    wr(3'd0, mkCtrl(1, 0, 4'd1, 20'd10));
    repeat (LDC) @(negedge clk);
    for (int j = 0; j <= 10; j++) begin
      rdReg(3'd4, rd);
      check($sformatf("R7 countdown step %0d", j), rd, 32'(10 - j));
      repeat (4) @(negedge clk);
    end
    repeat (20) @(negedge clk);
    rdReg(3'd4, rd); check("R9 count parked at zero", rd, 32'h0);
    check("R9 no request without reset enable", {31'b0, resetReq}, 32'h0);

    // R10 count enable clear
    doReset();
    wr(3'd0, mkCtrl(0, 1, 4'd3, 20'd5));
    repeat (LDC + 30) @(negedge clk);
    rdReg(3'd4, rd); check("R10 count held while disabled", rd, 32'd5);
    doReset();
    wr(3'd0, mkCtrl(0, 1, 4'd3, 20'd0));
    repeat (LDC + 20) @(negedge clk);
    check("R10 no request at zero while disabled", {31'b0, resetReq}, 32'h0);

    // R11 keepalive
    doReset();
    for (int i = 0; i < 10; i++) begin
      wr(3'd0, mkCtrl(1, 1, 4'd3, 20'd6));
      repeat (2) @(negedge clk);
    end
    check("R11 no request while refreshed", {31'b0, resetReq}, 32'h0);
    wr(3'd0, mkCtrl(1, 1, 4'd3, 20'd6));
    measure(k);
    check("R11 expiry after last refresh", 32'(k), 32'(LDC + 6 + 1));

    finishRun();
  end
endmodule